// File: doc/BRIEF.md
# Byte-Register ALU Executor

This block carries out the byte-oriented register instructions of a small 8-bit accumulator machine with 14-bit instruction words. Each cycle it may accept one instruction word, together with the operand already read from the addressed register. It decodes the opcode and computes an 8-bit result. The result goes either to its internal accumulator or out through a write port back to the addressed register. It updates the carry, digit-carry and zero flags as each operation requires.

A decrement-and-skip instruction whose result reaches zero raises a skip indication. The instruction slot that follows is then discarded, so the skip costs the sequencer a second cycle. An opcode outside the supported set is rejected: it leaves all state untouched and raises a one-cycle decode-error pulse. The register file, program counter and fetch logic live outside the block and connect to it through plain ports.

Top module: `regalu_exec`

## Requirements
- R1: Instruction fields are opcode = instr[13:8], destination bit = instr[7] and register address = instr[6:0]. When the destination bit is 1, reg_we is high for the cycle after the instruction is accepted, with reg_waddr equal to the address field and reg_wdata equal to the result. The accumulator keeps its value.
- R2: When the destination bit is 0, the result is loaded into the accumulator (acc_q, visible the cycle after acceptance) and reg_we stays low.
- R3: Opcodes 010100 (AND), 011111 (inclusive OR) and 011011 (exclusive OR) combine the accumulator with the operand bitwise. They update only the zero flag; carry and digit carry hold.
- R4: Opcode 010101 adds accumulator and operand. flag_c is the carry out of bit 7, flag_dc is the carry out of bit 3, and flag_z is set when the 8-bit sum is zero.
- R5: Opcode 011010 computes operand minus accumulator. flag_c is 1 when no borrow occurs (operand >= accumulator). flag_dc is 1 when the low nibble of the operand is >= the low nibble of the accumulator. flag_z marks a zero result.
- R6: Opcode 010110 computes operand minus one (modulo 256) and updates only the zero flag.
- R7: Opcode 010111 computes operand minus one and changes no flag. When that result is zero, skip_next is high for exactly the one cycle after acceptance.
- R8: An instruction presented while skip_next is high is discarded: no register write, no accumulator or flag change, no decode error.
- R9: Any other opcode causes no register write and no accumulator or flag change. decode_err is high for the one cycle after acceptance.
- R10: After reset, the accumulator, all flags, reg_we, skip_next and decode_err are 0. With instr_valid low, no state changes and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 14 | Instruction word |
| reg_rdata | input | 8 | Operand read from the addressed register |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 7 | Register write address |
| reg_wdata | output | 8 | Register write data |
| acc_q | output | 8 | Accumulator value |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Digit carry / nibble no-borrow flag |
| flag_z | output | 1 | Zero flag |
| skip_next | output | 1 | Next instruction slot is being skipped |
| decode_err | output | 1 | Unrecognised opcode seen |

## Verification
A corrupted accumulator or flag register shows at the ports one cycle after the instruction that wrote it. It also shows in the next result that depends on it, because every logical, add and subtract operation reads the accumulator back and the bench compares results against its own model. A stuck or missing skip state shows up in the following instruction slot: a write or accumulator change that should not happen, or a lost one that should. The bench places a decrement-and-skip with a zero result directly in front of writing instructions to expose this within two cycles.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_AND   = 6'b010100;
    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b010101;
    localparam logic [OPC_W-1:0] OPC_DEC   = 6'b010110;
    localparam logic [OPC_W-1:0] OPC_DECSZ = 6'b010111;
    localparam logic [OPC_W-1:0] OPC_SUB   = 6'b011010;
    localparam logic [OPC_W-1:0] OPC_XOR   = 6'b011011;
    localparam logic [OPC_W-1:0] OPC_IOR   = 6'b011111;

    typedef enum logic [2:0] {
        FN_AND, FN_IOR, FN_XOR, FN_ADD, FN_SUB, FN_DEC
    } alu_fn_e;

    typedef struct packed {
        logic    legal;
        alu_fn_e fn;
        logic    upd_cdc;
        logic    upd_z;
        logic    skip_zero;
    } ctrl_t;
endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
    import regalu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ctrl_t            ctrl
);
    always_comb begin
        ctrl = '{legal: 1'b1, fn: FN_AND, upd_cdc: 1'b0, upd_z: 1'b1, skip_zero: 1'b0};
        case (opc)
            OPC_AND:   ctrl.fn = FN_AND;
            OPC_IOR:   ctrl.fn = FN_IOR;
            OPC_XOR:   ctrl.fn = FN_XOR;
            OPC_ADD: begin
                ctrl.fn      = FN_ADD;
                ctrl.upd_cdc = 1'b1;
            end
            OPC_SUB: begin
                ctrl.fn      = FN_SUB;
                ctrl.upd_cdc = 1'b1;
            end
            OPC_DEC:   ctrl.fn = FN_DEC;
            OPC_DECSZ: begin
                ctrl.fn        = FN_DEC;
                ctrl.upd_z     = 1'b0;
                ctrl.skip_zero = 1'b1;
            end
            default: begin
                ctrl.legal = 1'b0;
                ctrl.upd_z = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regalu_core.sv
module regalu_core
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              dc_out
);
    localparam int NIB = 4;

    logic [DATA_W:0] sum_w, dif_w;
    logic [NIB:0]    sum_n, dif_n;

    always_comb begin
        sum_w  = {1'b0, acc} + {1'b0, opnd};
        dif_w  = {1'b0, opnd} - {1'b0, acc};
        sum_n  = {1'b0, acc[NIB-1:0]} + {1'b0, opnd[NIB-1:0]};
        dif_n  = {1'b0, opnd[NIB-1:0]} - {1'b0, acc[NIB-1:0]};
        c_out  = 1'b0;
        dc_out = 1'b0;
        case (fn)
            FN_AND: res = acc & opnd;
            FN_IOR: res = acc | opnd;
            FN_XOR: res = acc ^ opnd;
            FN_ADD: begin
                res    = sum_w[DATA_W-1:0];
                c_out  = sum_w[DATA_W];
                dc_out = sum_n[NIB];
            end
            FN_SUB: begin
                res    = dif_w[DATA_W-1:0];
                c_out  = ~dif_w[DATA_W];
                dc_out = ~dif_n[NIB];
            end
            default: res = opnd - {{(DATA_W-1){1'b0}}, 1'b1};
        endcase
    end
endmodule

// File: rtl/regalu_exec.sv
module regalu_exec
    import regalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_valid,
    input  logic [OPC_W+ADDR_W:0]     instr,
    input  logic [DATA_W-1:0]         reg_rdata,
    output logic                      reg_we,
    output logic [ADDR_W-1:0]         reg_waddr,
    output logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         acc_q,
    output logic                      flag_c,
    output logic                      flag_dc,
    output logic                      flag_z,
    output logic                      skip_next,
    output logic                      decode_err
);
    localparam int DST_BIT = ADDR_W;
    localparam int OPC_LSB = ADDR_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              c;
        logic              dc;
        logic              z;
        logic              skip;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
        logic              err;
    } state_t;

    state_t            st_d, st_q;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] res;
    logic              c_new, dc_new;

    regalu_decode u_dec (
        .opc  (instr[OPC_LSB +: OPC_W]),
        .ctrl (ctrl)
    );

    regalu_core #(.DATA_W(DATA_W)) u_core (
        .fn     (ctrl.fn),
        .acc    (st_q.acc),
        .opnd   (reg_rdata),
        .res    (res),
        .c_out  (c_new),
        .dc_out (dc_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.err  = 1'b0;
        st_d.skip = 1'b0;
        if (instr_valid && !st_q.skip) begin
            if (!ctrl.legal) begin
                st_d.err = 1'b1;
            end else begin
                if (instr[DST_BIT]) begin
                    st_d.we    = 1'b1;
                    st_d.waddr = instr[ADDR_W-1:0];
                    st_d.wdata = res;
                end else begin
                    st_d.acc = res;
                end
                if (ctrl.upd_cdc) begin
                    st_d.c  = c_new;
                    st_d.dc = dc_new;
                end
                if (ctrl.upd_z) st_d.z = (res == '0);
                if (ctrl.skip_zero && res == '0) st_d.skip = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_we     = st_q.we;
    assign reg_waddr  = st_q.waddr;
    assign reg_wdata  = st_q.wdata;
    assign acc_q      = st_q.acc;
    assign flag_c     = st_q.c;
    assign flag_dc    = st_q.dc;
    assign flag_z     = st_q.z;
    assign skip_next  = st_q.skip;
    assign decode_err = st_q.err;

    a_r7_skip_single: assert property (@(posedge clk) disable iff (!rst_n)
        skip_next |=> !skip_next);
    a_r7_skip_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        skip_next |-> {flag_c, flag_dc, flag_z} == $past({flag_c, flag_dc, flag_z}));
    a_r8_skip_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
        skip_next |=> (!reg_we && !decode_err && $stable(acc_q)
                       && $stable({flag_c, flag_dc, flag_z})));
    a_r9_err_inert: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> (!reg_we && acc_q == $past(acc_q)
                        && {flag_c, flag_dc, flag_z} == $past({flag_c, flag_dc, flag_z})));
    a_r1_write_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> acc_q == $past(acc_q));
endmodule

// File: tb/sim_regalu_exec.sv
module sim_regalu_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [13:0] instr = '0;
    logic [7:0]  reg_rdata = '0;
    logic        reg_we, flag_c, flag_dc, flag_z, skip_next, decode_err;
    logic [6:0]  reg_waddr;
    logic [7:0]  reg_wdata, acc_q;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_acc = '0;
    logic       m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0, m_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regalu_exec u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .acc_q(acc_q), .flag_c(flag_c), .flag_dc(flag_dc),
        .flag_z(flag_z), .skip_next(skip_next), .decode_err(decode_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_legal(input logic [5:0] op);
        return op inside {6'b010100, 6'b010101, 6'b010110, 6'b010111,
                          6'b011010, 6'b011011, 6'b011111};
    endfunction

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'b010100, 6'b011011, 6'b011111: return "R3";
            6'b010101: return "R4";
            6'b011010: return "R5";
            6'b010110: return "R6";
            6'b010111: return "R7";
            default:   return "R9";
        endcase
    endfunction

    // executes one instruction slot; called at a falling edge
    task automatic run(input logic [5:0] op, input logic d, input logic [6:0] a,
                       input logic [7:0] r);
        int         sum;
        logic [7:0] res;
        logic       e_we, e_err, e_skip;
        string      tag;
        instr_valid = 1'b1;
        instr       = {op, d, a};
        reg_rdata   = r;
        e_we = 1'b0; e_err = 1'b0; e_skip = 1'b0; res = '0;
        tag = tag_of(op);
        if (m_pend) begin
            tag = "R8";
        end else if (!is_legal(op)) begin
            e_err = 1'b1;
        end else begin
            case (op)
                6'b010100: begin res = m_acc & r; m_z = (res == 0); end
                6'b011111: begin res = m_acc | r; m_z = (res == 0); end
                6'b011011: begin res = m_acc ^ r; m_z = (res == 0); end
                6'b010101: begin
                    sum  = int'(m_acc) + int'(r);
                    res  = sum[7:0];
                    m_c  = (sum > 255);
                    m_dc = (int'(m_acc[3:0]) + int'(r[3:0])) > 15;
                    m_z  = (res == 0);
                end
                6'b011010: begin
                    res  = r - m_acc;
                    m_c  = (r >= m_acc);
                    m_dc = (r[3:0] >= m_acc[3:0]);
                    m_z  = (res == 0);
                end
                6'b010110: begin res = r - 8'd1; m_z = (res == 0); end
                default: begin res = r - 8'd1; e_skip = (res == 0); end
            endcase
            if (d) e_we = 1'b1;
            else   m_acc = res;
        end
        @(negedge clk);
        chk(tag, "reg_we", reg_we, e_we);
        if (e_we) begin
            chk("R1", "reg_waddr", reg_waddr, a);
            chk("R1", "reg_wdata", reg_wdata, res);
        end
        chk(d ? "R1" : "R2", "acc_q", acc_q, m_acc);
        chk(tag, "flag_c", flag_c, m_c);
        chk(tag, "flag_dc", flag_dc, m_dc);
        chk(tag, "flag_z", flag_z, m_z);
        chk(tag, "skip_next", skip_next, e_skip);
        chk(tag, "decode_err", decode_err, e_err);
        m_pend = e_skip;
    endtask

    task automatic idle();
        instr_valid = 1'b0;
        instr = {6'b010101, 1'b0, 7'h11};
        reg_rdata = 8'h5A;
        @(negedge clk);
        chk("R10", "idle reg_we", reg_we, 0);
        chk("R10", "idle acc_q", acc_q, m_acc);
        chk("R10", "idle decode_err", decode_err, 0);
        m_pend = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [5:0] legal_ops [7] = '{6'b010100, 6'b010101, 6'b010110, 6'b010111,
                                      6'b011010, 6'b011011, 6'b011111};
        void'($urandom(32'd24601));
        repeat (3) @(negedge clk);
        chk("R10", "reset acc_q", acc_q, 0);
        chk("R10", "reset flags", {flag_c, flag_dc, flag_z}, 0);
        chk("R10", "reset reg_we", reg_we, 0);
        chk("R10", "reset skip_next", skip_next, 0);
        chk("R10", "reset decode_err", decode_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(6'b011111, 1'b0, 7'h05, 8'h0F);   // R2: acc = 0F
        run(6'b010101, 1'b1, 7'h20, 8'h01);   // R4 nibble carry, R1 write
        run(6'b011111, 1'b0, 7'h05, 8'hF0);   // acc = FF
        run(6'b010101, 1'b0, 7'h06, 8'h01);   // R4: 0, C=1, DC=1, Z=1
        run(6'b011111, 1'b0, 7'h07, 8'h33);   // acc = 33
        run(6'b011010, 1'b1, 7'h08, 8'h33);   // R5 equal
        run(6'b011010, 1'b1, 7'h09, 8'h12);   // R5 borrow
        run(6'b010111, 1'b1, 7'h0A, 8'h01);   // R7 zero, skip
        run(6'b011111, 1'b0, 7'h0B, 8'hAA);   // R8 discarded
        run(6'b010111, 1'b0, 7'h0C, 8'h00);   // R7 wrap to FF, no skip
        run(6'b010111, 1'b0, 7'h0D, 8'h01);   // R7 skip, d=0
        run(6'b111111, 1'b1, 7'h0E, 8'h00);   // R8: illegal in skip slot
        run(6'b000000, 1'b1, 7'h0F, 8'h00);   // R9
        run(6'b010110, 1'b1, 7'h10, 8'h00);   // R6 wrap
        idle();

        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            logic [7:0] r;
            int sel = int'($urandom_range(0, 8));
            if (sel < 7) op = legal_ops[sel];
            else begin
                op = 6'($urandom);
                while (is_legal(op)) op = 6'($urandom);
            end
            case ($urandom_range(0, 3))
                0:       r = 8'h01;
                1:       r = m_acc;
                default: r = 8'($urandom);
            endcase
            run(op, 1'($urandom), 7'($urandom), r);
            if ($urandom_range(0, 30) == 0) idle();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule